// File: doc/BRIEF.md
# Clock Post-Scaler and Output Stage

This block is the digital output stage of a clock synthesizer. It runs entirely on one fast system clock. Edges of the oscillator it stands in for arrive as single-cycle tick pulses, either from the synthesized source or from the reference input, and one pulse marks one edge of that source. A two-bit select either divides the selected source by 1, 2 or 4 onto a complementary output pair, or hands both outputs over to software-held bits (auxiliary mode). A programmable LOAD divider counts periods of the scaled clock, and a second programmable divider is clocked from the rising edges of LOAD.

Control bits let the LOAD divider be bypassed by a fixed half-rate toggle, freeze the differential pair high/low while everything else keeps running, and clear the dividers. The freeze releases in step with a rising edge of LOAD, so a downstream converter that is clocked by the pair restarts in a known relation to its load strobe.

Top module: `clk_post_stage`

## Requirements
- R1: With mode 00, 01 or 10 and an edge pulse on every cycle, clk_p changes level after every 1, 2 or 4 selected edge pulses respectively (no pulse, no change).
- R2: ref_sel=1 takes the edge pulses from ref_tick; ref_sel=0 takes them from src_tick.
- R3: The LOAD divider advances on each rising edge of the scaled clock with modulus n1_mod (values below 2 act as 2). Of every N scaled periods LOAD is high for N/2 (rounded down) and low for the rest.
- R4: The second divider advances on each rising edge of LOAD with modulus n2_mod (values below 2 act as 2), and n2_out is high for n2_mod/2 (rounded down) of every n2_mod LOAD periods.
- R5: Mode 11 (auxiliary) makes clk_p follow aux_clk and LOAD follow aux_n1, starting one cycle after the mode is applied. Rising edges of aux_n1 clock the second divider.
- R6: Outside mode 11, aux_n1=1 replaces the LOAD divider: LOAD changes level every 2 selected edge pulses.
- R7: From the cycle after hold is sampled high, clk_p=1 and clk_n=0. LOAD and n2_out keep running.
- R8: After hold returns to 0, the pair stays frozen until the first rising edge of LOAD, and it resumes at that point.
- R9: While cnt_rst is 1, the LOAD divider, the half-rate override and the second divider are cleared, and LOAD and n2_out are held low outside mode 11. The post-scaler keeps running.
- R10: Except while frozen, clk_n is the exact complement of clk_p.
- R11: A change of mode clears the post-scaler count, and the edge pulse in the cycle of the change is ignored. The first level change afterwards therefore comes no sooner than the new ratio allows.
- R12: Synchronous reset gives clk_p=0, clk_n=1, LOAD=0 and n2_out=0, clears all counters and selects divide-by-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 1 | Edge pulse of the synthesized source |
| ref_tick | input | 1 | Edge pulse of the reference input |
| ref_sel | input | 1 | 1 selects ref_tick as the post-scaler source |
| mode | input | 2 | 00 /1, 01 /2, 10 /4, 11 auxiliary |
| aux_clk | input | 1 | Pair level in auxiliary mode |
| aux_n1 | input | 1 | LOAD level in auxiliary mode; half-rate override otherwise |
| hold | input | 1 | Freeze the differential pair |
| cnt_rst | input | 1 | Clear the dividers |
| n1_mod | input | N1W | LOAD divider modulus |
| n2_mod | input | N2W | Second divider modulus |
| clk_p | output | 1 | Differential output, true side |
| clk_n | output | 1 | Differential output, complement side |
| load | output | 1 | LOAD strobe |
| n2_out | output | 1 | Second divider output |

## Verification
On every cycle the assertions check the complement relation of the pair, that a sampled hold freezes the pair on the next cycle, and that the freeze ends only at a LOAD rising edge. They also check that a divider clear forces LOAD and n2_out low, and the reset values. Division ratios, LOAD and n2_out duty cycles, the source choice, the half-rate override, auxiliary mode and the guard on select changes are rate and sequence properties. Only the bench's scenarios show these, by counting level changes and high cycles over windows that are whole multiples of the expected period.

// File: rtl/clk_post_stage.sv
`timescale 1ns/1ps
module clk_post_stage #(
  parameter int N1W = 8,
  parameter int N2W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           src_tick,
  input  logic           ref_tick,
  input  logic           ref_sel,
  input  logic [1:0]     mode,
  input  logic           aux_clk,
  input  logic           aux_n1,
  input  logic           hold,
  input  logic           cnt_rst,
  input  logic [N1W-1:0] n1_mod,
  input  logic [N2W-1:0] n2_mod,
  output logic           clk_p,
  output logic           clk_n,
  output logic           load,
  output logic           n2_out
);
  localparam logic [1:0] SEL_DIV2 = 2'b01;
  localparam logic [1:0] SEL_DIV4 = 2'b10;
  localparam logic [1:0] SEL_AUX  = 2'b11;
  localparam logic [N1W-1:0] N1_ONE = 1;
  localparam logic [N1W-1:0] N1_TWO = 2;
  localparam logic [N2W-1:0] N2_ONE = 1;
  localparam logic [N2W-1:0] N2_TWO = 2;

  logic [1:0]     mode_q, ps_cnt, ps_last;
  logic           tick, aux_mode, mode_chg, ps_fire, scl_rise;
  logic           scl, held, ov_cnt, ov_q, n1_q, n2_q, load_d, load_rise, drv;
  logic [N1W-1:0] n1_cnt, n1_eff, n1_hi;
  logic [N2W-1:0] n2_cnt, n2_eff, n2_hi;

  assign tick     = ref_sel ? ref_tick : src_tick;
  assign aux_mode = (mode_q == SEL_AUX);
  assign mode_chg = (mode != mode_q);

  always_comb begin
    case (mode_q)
      SEL_DIV2: ps_last = 2'd1;
      SEL_DIV4: ps_last = 2'd3;
      default:  ps_last = 2'd0;
    endcase
  end

  assign ps_fire  = tick && !mode_chg && !aux_mode && (ps_cnt >= ps_last);
  assign scl_rise = ps_fire && !scl;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'b00;
      ps_cnt <= 2'd0;
      scl    <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= mode;
      ps_cnt <= 2'd0;
    end else if (tick && !aux_mode) begin
      if (ps_fire) begin
        ps_cnt <= 2'd0;
        scl    <= ~scl;
      end else begin
        ps_cnt <= ps_cnt + 2'd1;
      end
    end
  end

  assign n1_eff = (n1_mod < N1_TWO) ? N1_TWO : n1_mod;
  assign n1_hi  = n1_eff - (n1_eff >> 1);

  always_ff @(posedge clk) begin
    if (rst || cnt_rst) begin
      n1_cnt <= '0;
      n1_q   <= 1'b0;
    end else if (scl_rise) begin
      if (n1_cnt >= n1_eff - N1_ONE) begin
        n1_cnt <= '0;
        n1_q   <= 1'b0;
      end else begin
        n1_cnt <= n1_cnt + N1_ONE;
        n1_q   <= (n1_cnt + N1_ONE) >= n1_hi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_rst) begin
      ov_cnt <= 1'b0;
      ov_q   <= 1'b0;
    end else if (tick) begin
      ov_cnt <= ~ov_cnt;
      if (ov_cnt) ov_q <= ~ov_q;
    end
  end

  assign load      = aux_mode ? aux_n1 : (aux_n1 ? ov_q : n1_q);
  assign load_rise = load && !load_d;

  always_ff @(posedge clk) begin
    if (rst) load_d <= 1'b0;
    else     load_d <= load;
  end

  assign n2_eff = (n2_mod < N2_TWO) ? N2_TWO : n2_mod;
  assign n2_hi  = n2_eff - (n2_eff >> 1);

  always_ff @(posedge clk) begin
    if (rst || cnt_rst) begin
      n2_cnt <= '0;
      n2_q   <= 1'b0;
    end else if (load_rise) begin
      if (n2_cnt >= n2_eff - N2_ONE) begin
        n2_cnt <= '0;
        n2_q   <= 1'b0;
      end else begin
        n2_cnt <= n2_cnt + N2_ONE;
        n2_q   <= (n2_cnt + N2_ONE) >= n2_hi;
      end
    end
  end

  assign n2_out = n2_q;

  always_ff @(posedge clk) begin
    if (rst)                    held <= 1'b0;
    else if (hold)              held <= 1'b1;
    else if (held && load_rise) held <= 1'b0;
  end

  assign drv   = aux_mode ? aux_clk : scl;
  assign clk_p = held | drv;
  assign clk_n = !held && !drv;
endmodule

// File: rtl/clk_post_stage_chk.sv
`timescale 1ns/1ps
module clk_post_stage_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold,
  input logic       cnt_rst,
  input logic [1:0] mode,
  input logic       aux_mode,
  input logic       held,
  input logic       clk_p,
  input logic       clk_n,
  input logic       load,
  input logic       n2_out
);
  assert_pair_complement_R10: assert property (@(posedge clk) disable iff (rst)
    (clk_n != clk_p) || (clk_p && !clk_n));

  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (rst)
    hold |=> (clk_p && !clk_n));

  assert_release_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> ($past(load) && !$past(load, 2)));

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_rst && !aux_mode && mode != 2'b11) |=> (!load && !n2_out));

  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> (!clk_p && clk_n && !load && !n2_out));
endmodule

bind clk_post_stage clk_post_stage_chk chk (
  .clk(clk), .rst(rst), .hold(hold), .cnt_rst(cnt_rst), .mode(mode),
  .aux_mode(aux_mode), .held(held), .clk_p(clk_p), .clk_n(clk_n),
  .load(load), .n2_out(n2_out)
);

// File: tb/tb_clk_post_stage.sv
`timescale 1ns/1ps
module tb_clk_post_stage;
  logic       clk = 1'b0;
  logic       rst, src_tick, ref_tick, ref_sel, aux_clk, aux_n1, hold, cnt_rst;
  logic [1:0] mode;
  logic [7:0] n1_mod, n2_mod;
  logic       clk_p, clk_n, load, n2_out;
  int checks = 0;
  int errors = 0;
  int tog, lhi, lrise, n2hi, cbad, frozen;
  logic prev_p, prev_l;

  always #2.5 clk = ~clk;

  clk_post_stage dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .ref_tick(ref_tick),
    .ref_sel(ref_sel), .mode(mode), .aux_clk(aux_clk), .aux_n1(aux_n1),
    .hold(hold), .cnt_rst(cnt_rst), .n1_mod(n1_mod), .n2_mod(n2_mod),
    .clk_p(clk_p), .clk_n(clk_n), .load(load), .n2_out(n2_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; src_tick = 1; ref_tick = 0; ref_sel = 0; mode = 2'b00;
    aux_clk = 0; aux_n1 = 0; hold = 0; cnt_rst = 0; n1_mod = 8'd4; n2_mod = 8'd2;
    repeat (3) @(negedge clk);
    rst = 0;
    prev_p = clk_p; prev_l = load;
  endtask

  // sample n cycles at negedges, counting pair changes, LOAD stats, n2 high, complement errors
  task automatic run(input int n);
    tog = 0; lhi = 0; lrise = 0; n2hi = 0; cbad = 0; frozen = 0;
    prev_p = clk_p; prev_l = load;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_p != prev_p) tog++;
      if (load) lhi++;
      if (load && !prev_l) lrise++;
      if (n2_out) n2hi++;
      if (clk_n == clk_p) cbad++;
      if (clk_p && !clk_n) frozen++;
      prev_p = clk_p; prev_l = load;
    end
  endtask

  task automatic t_reset();
    do_reset();
    rst = 1;
    @(negedge clk);
    check(!clk_p && clk_n, "R12 pair in reset", {clk_p, clk_n}, 1);
    check(!load && !n2_out, "R12 load/n2 in reset", {load, n2_out}, 0);
    rst = 0;
    run(10);
    check(tog == 10, "R12 divide-by-1 after reset", tog, 10);
    check(cbad == 0, "R10 complement", cbad, 0);
  endtask

  task automatic t_divide();
    do_reset();
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      run(8);
      run(40);
      check(tog == 40 / (1 << m), "R1 toggles per window", tog, 40 / (1 << m));
      check(cbad == 0, "R10 complement", cbad, 0);
    end
    src_tick = 0;
    run(10);
    check(tog == 0, "R1 no pulse no change", tog, 0);
  endtask

  task automatic t_ref();
    do_reset();
    ref_sel = 1;
    fork
      begin
        for (int i = 0; i < 60; i++) begin ref_tick = (i % 2 == 0); @(negedge clk); end
      end
      begin
        run(8);
        run(40);
      end
    join
    ref_tick = 0;
    check(tog == 20, "R2 reference source rate", tog, 20);
    ref_sel = 0;
    run(4);
    run(20);
    check(tog == 20, "R2 synthesized source rate", tog, 20);
  endtask

  task automatic t_n1();
    do_reset();
    n1_mod = 8'd5; n2_mod = 8'd3;
    run(40);
    run(120);
    check(lrise == 12, "R3 LOAD period N1=5", lrise, 12);
    check(lhi == 48, "R3 LOAD high time N1=5", lhi, 48);
    check(n2hi == 40, "R4 n2 high time N2=3", n2hi, 40);
    n1_mod = 8'd1;
    run(20);
    run(40);
    check(lrise == 10, "R3 modulus below 2 acts as 2", lrise, 10);
    check(lhi == 20, "R3 LOAD duty N1=2", lhi, 20);
  endtask

  task automatic t_override();
    do_reset();
    n1_mod = 8'd7; mode = 2'b01; aux_n1 = 1;
    run(10);
    run(40);
    check(lrise == 10, "R6 override LOAD period", lrise, 10);
    check(lhi == 20, "R6 override LOAD duty", lhi, 20);
    check(tog == 20, "R6 pair unaffected", tog, 20);
  endtask

  task automatic t_aux();
    do_reset();
    mode = 2'b11; aux_clk = 1; aux_n1 = 0; n2_mod = 8'd2;
    repeat (2) @(negedge clk);
    check(clk_p && !clk_n, "R5 aux_clk=1 drives pair", clk_p, 1);
    check(!load, "R5 aux_n1=0 drives LOAD", load, 0);
    aux_clk = 0; aux_n1 = 1;
    @(negedge clk);
    check(!clk_p && clk_n, "R5 aux_clk=0 drives pair", clk_p, 0);
    check(load, "R5 aux_n1=1 drives LOAD", load, 1);
    repeat (2) @(negedge clk);
    check(n2_out, "R4 aux LOAD edge clocks n2", n2_out, 1);
    aux_n1 = 0; repeat (3) @(negedge clk);
    aux_n1 = 1; repeat (3) @(negedge clk);
    check(!n2_out, "R4 second aux edge returns n2", n2_out, 0);
  endtask

  task automatic t_hold();
    int seen, bad, wait_n;
    do_reset();
    n1_mod = 8'd8;
    run(20);
    hold = 1;
    @(negedge clk);
    run(48);
    check(frozen == 48, "R7 pair frozen high/low", frozen, 48);
    check(lrise == 3, "R7 LOAD keeps running", lrise, 3);
    while (load) @(negedge clk);
    hold = 0;
    seen = 0; bad = 0; wait_n = 0;
    for (int i = 0; i < 40 && wait_n < 3; i++) begin
      @(negedge clk);
      if (!seen) begin
        if (!(clk_p && !clk_n)) bad++;
        if (load) seen = 1;
      end else begin
        wait_n++;
        if (!clk_p) wait_n = 10;
      end
    end
    check(seen == 1 && bad == 0, "R8 frozen until LOAD rise", bad, 0);
    check(wait_n == 10, "R8 resumes after LOAD rise", wait_n, 10);
  endtask

  task automatic t_cntrst();
    do_reset();
    n1_mod = 8'd4; n2_mod = 8'd2;
    run(30);
    cnt_rst = 1;
    @(negedge clk);
    run(20);
    check(lhi == 0 && n2hi == 0, "R9 LOAD/n2 held low", lhi + n2hi, 0);
    check(tog == 20, "R9 post-scaler keeps running", tog, 20);
    cnt_rst = 0;
    run(80);
    check(lrise == 10, "R9 LOAD resumes", lrise, 10);
  endtask

  task automatic t_modechg();
    int gap;
    do_reset();
    mode = 2'b10;
    run(12);
    prev_p = clk_p;
    @(negedge clk);
    while (clk_p == prev_p) begin prev_p = clk_p; @(negedge clk); end
    @(negedge clk);
    prev_p = clk_p;
    mode = 2'b01;
    gap = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      gap++;
      if (clk_p != prev_p) break;
    end
    check(gap >= 2, "R11 first change after select switch", gap, 3);
    run(40);
    check(tog == 20, "R11 new ratio steady", tog, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_divide();
    t_ref();
    t_n1();
    t_override();
    t_aux();
    t_hold();
    t_cntrst();
    t_modechg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule